// File: doc/BRIEF.md
# Simple Dual-Port RAM with Old-Data Collision Read

This block is a single-clock memory with one write port and one read port. Both ports can be used on every clock edge without any gap between accesses. A write stores its data at the rising edge on which it is presented. A read presented at the same edge captures the word held at that location into an output register.

The case that needs care is a read and a write to the same location at the same edge. Here the read returns the word held just before that edge, and the write still replaces that word. Because the read result is taken from the array before the write lands and is held in a register, the returned value is always defined. It is never a mix of old and new bits. The same rule holds when several collisions on one location follow each other: each read returns the word stored by the write before it.

Data width and depth are parameters. The stored words have no reset value, so a location must be written before its read result means anything. The output register is cleared by reset.

Top module: `dpram_od`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_q` becomes all zeros at that edge.
- R2: A read with `rd_en` high presented at edge N returns, after edge N, the word most recently written to `rd_addr` at an edge before N.
- R3: When `rd_en` is low at an edge, `rd_q` keeps its previous value, whatever the write port does at that edge.
- R4: When `rd_en` and `wr_en` are both high at one edge and `rd_addr` equals `wr_addr`, `rd_q` returns the word held before that edge, not `wr_data`.
- R5: In the collision case of R4, `wr_data` is still stored, so a later read of that address returns it.
- R6: A write to an address different from `rd_addr` at the same edge has no effect on the value returned by that read.
- R7: When `wr_en` is low, no location changes, whatever `wr_addr` and `wr_data` hold.
- R8: Back-to-back collisions on one address, one per edge, each return the word written by the collision at the edge before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read output register |
| wr_en | input | 1 | Write request for this edge |
| wr_addr | input | $clog2(DEPTH) | Location to write |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request for this edge |
| rd_addr | input | $clog2(DEPTH) | Location to read |
| rd_q | output | DW | Registered read result |

## Verification
Each read result is due exactly one rising edge after its request. The result is ready on `rd_q` after that same edge that stores a concurrent write. A collision read therefore shows the older word in the very cycle after the edge, and the newer word shows up only on a read at a later edge. The bench drives every request on a falling edge and samples `rd_q` on the following falling edge. It compares against an array model whose expected read value is taken before that cycle's write is applied to the model. Sweeps cover every address for plain reads, same-address collisions, different-address concurrent writes, disabled writes and held outputs.

// File: rtl/dpram_od_pkg.sv
package dpram_od_pkg;

    // Default geometry of the memory.
    localparam int unsigned DEF_DW    = 16;
    localparam int unsigned DEF_DEPTH = 32;

    // Which way the read stage chooses its next value.
    typedef enum logic [1:0] {
        RSEL_HOLD  = 2'd0,
        RSEL_CLEAR = 2'd1,
        RSEL_LOAD  = 2'd2
    } rsel_e;

    // Decide the read stage action; reset wins over a read.
    function automatic rsel_e pick_rsel(input logic rst_i, input logic rd_en_i);
        rsel_e r;
        if (rst_i)        r = RSEL_CLEAR;
        else if (rd_en_i) r = RSEL_LOAD;
        else              r = RSEL_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/dpram_od_array.sv
// Storage array: written at the clock edge, read combinationally so that
// the value seen at an edge is the contents before that edge's write.
module dpram_od_array #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rword = cells[raddr];

endmodule

// File: rtl/dpram_od_rdreg.sv
// Output register of the read port: load, hold or clear.
module dpram_od_rdreg
    import dpram_od_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] q
);

    rsel_e         sel;
    logic [DW-1:0] q_next;

    always_comb begin
        sel = pick_rsel(rst, ren);
        unique case (sel)
            RSEL_CLEAR: q_next = '0;
            RSEL_LOAD:  q_next = word_in;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_next;
    end

endmodule

// File: rtl/dpram_od.sv
// Single-clock simple dual-port RAM returning old data on a collision.
module dpram_od
    import dpram_od_pkg::*;
#(
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wreq_t;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } rreq_t;

    wreq_t         wq;
    rreq_t         rq;
    logic [DW-1:0] arr_word;

    assign wq = '{en: wr_en, addr: wr_addr, data: wr_data};
    assign rq = '{en: rd_en, addr: rd_addr};

    dpram_od_array #(
        .DW(DW), .DEPTH(DEPTH), .AW(AW)
    ) u_array (
        .clk   (clk),
        .we    (wq.en),
        .waddr (wq.addr),
        .wdata (wq.data),
        .raddr (rq.addr),
        .rword (arr_word)
    );

    dpram_od_rdreg #(
        .DW(DW)
    ) u_rdreg (
        .clk     (clk),
        .rst     (rst),
        .ren     (rq.en),
        .word_in (arr_word),
        .q       (rd_q)
    );

endmodule

// File: rtl/dpram_od_chk.sv
// Port-level checker for dpram_od.
module dpram_od_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (rd_q == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

    // R2
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en ##1 (rd_en && rd_addr == $past(wr_addr)))
        |=> (rd_q == $past(wr_data, 2)));

    // R4
    collision_old_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en ##1 (rd_en && wr_en && rd_addr == wr_addr
                    && rd_addr == $past(wr_addr)))
        |=> (rd_q == $past(wr_data, 2)));

endmodule

bind dpram_od dpram_od_chk #(
    .DW(DW), .AW(AW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
);

// File: tb/dpram_od_bench.sv
module dpram_od_bench;

    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_q;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] model [DEPTH];

    always #2 clk = ~clk;

    dpram_od #(.DW(DW), .DEPTH(DEPTH)) u_dpram_od (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_q)
    );

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return DW'((a * 16'h0123 + pass * 16'h1F01 + 16'h5A00) & 16'hFFFF);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] exp);
        total++;
        if (rd_q !== exp) begin
            bad++;
            $display("FAIL %s: rd_q=%h expected=%h", req, rd_q, exp);
        end
    endtask

    // One edge: drive at falling edge, sample at the next falling edge.
    task automatic cyc(input string req, input logic we, input int wa,
                       input logic [DW-1:0] wd, input logic re, input int ra);
        logic [DW-1:0] exp;
        exp     = re ? model[ra] : rd_q;
        wr_en   = we;
        wr_addr = AW'(wa);
        wr_data = wd;
        rd_en   = re;
        rd_addr = AW'(ra);
        if (we) model[wa] = wd;
        @(negedge clk);
        check(req, exp);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", '0);
        rst = 1'b0;

        // Fill every location, no reads.
        for (int a = 0; a < DEPTH; a++) cyc("R2", 1'b1, a, pat(a, 0), 1'b0, 0);
        // Read back every location.
        for (int a = 0; a < DEPTH; a++) cyc("R2", 1'b0, 0, '0, 1'b1, a);
        // Same-address collisions: old word returned.
        for (int a = 0; a < DEPTH; a++) cyc("R4", 1'b1, a, pat(a, 1), 1'b1, a);
        // New word stored by the collision.
        for (int a = 0; a < DEPTH; a++) cyc("R5", 1'b0, 0, '0, 1'b1, a);
        // Concurrent write elsewhere does not disturb the read.
        for (int a = 0; a < DEPTH; a++)
            cyc("R6", 1'b1, (a + 1) % DEPTH, pat(a, 2), 1'b1, a);
        // Read disabled: output holds while writes go on.
        cyc("R3", 1'b0, 0, '0, 1'b1, 7);
        for (int k = 0; k < 6; k++) cyc("R3", 1'b1, 7, pat(k, 3), 1'b0, k);
        // Write disabled: address and data ignored.
        for (int a = 0; a < DEPTH; a++) begin
            wr_en = 1'b0; wr_addr = AW'(a); wr_data = ~pat(a, 4);
            rd_en = 1'b0;
            @(negedge clk);
            cyc("R7", 1'b0, a, ~pat(a, 5), 1'b1, a);
        end
        // Back-to-back collisions on one address.
        for (int k = 0; k < 8; k++) cyc("R8", 1'b1, 5, pat(k, 6), 1'b1, 5);
        cyc("R8", 1'b0, 0, '0, 1'b1, 5);
        // Reset clears output after activity.
        rst = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        check("R1", '0);
        rst = 1'b0; rd_en = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule